// File: doc/BRIEF.md
# Random-Duty Fixed-Frequency PWM Generator

This block drives one pulse-width-modulated output at a fixed frequency while picking a new duty value at random for every period. A free-running up counter sets the period. A maximal-length linear feedback shift register supplies the random numbers, and it steps once per period. A duty register holds the value in use, and a magnitude comparator turns the count and the duty into the pulse. Because only the pulse width moves and the frequency stays fixed, the switching energy is spread across the spectrum. This suits loads that must not see a variable switching frequency.

The duty register only takes a new value on the cycle where the counter rolls from all-ones back to zero. A period therefore always uses one compare value from start to end. A polarity input picks active-high or active-low output. An enable input freezes the whole time base and parks the output at its inactive level. The duty value in use and a strobe marking the start of each period are brought out for the surrounding logic.

Top module: `rdpwm_top`

## Requirements
- R1: While enable stays high, the counter runs modulo 2^CNT_W, so wrap_o pulses exactly once every 2^CNT_W clock cycles (256 at the default CNT_W of 8).
- R2: With enable high and pol low, pwm_o is 1 while the counter is below duty_o and 0 otherwise.
- R3: With enable high and pol high, pwm_o is the inverse of the R2 level: 0 while the counter is below duty_o and 1 otherwise.
- R4: duty_o changes only on the enabled cycle where the counter steps from all-ones to zero. It then takes the current shift-register state. The first period after reset runs with duty 0, the second with the seed, and later periods with the successive register states.
- R5: wrap_o is high for exactly the enabled cycles on which the counter equals zero. It is never high for two cycles in a row.
- R6: The shift register moves left by one bit per period, with the new bit 0 equal to the XOR of a fixed set of state bits. At CNT_W = 8 these are bits 7, 5, 4 and 3. The state is never zero, and the duty sequence repeats only after 2^CNT_W - 1 periods (255 at the default).
- R7: While en is low, the counter, the shift register and duty_o hold their values, wrap_o is 0, and pwm_o sits at its inactive level, which equals pol.
- R8: A synchronous reset clears the counter and duty_o to zero and loads the shift register with the nonzero seed SEED (default 165, hex A5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low freezes the time base and idles the output |
| pol | input | 1 | Output polarity: 0 active high, 1 active low |
| pwm_o | output | 1 | Modulated output |
| wrap_o | output | 1 | One-cycle strobe at the first cycle of each period |
| duty_o | output | CNT_W | Compare value used in the current period |

## Verification
The hardest case to reach from the ports is an enable drop on the exact cycle the counter sits at all-ones. If it happens, the reload must not occur, and the reload must then happen on the first enabled edge afterwards. The bench keeps its own copy of the counter and steps the stimulus cycle by cycle against it. This lets it lower en at that cycle and at a mid-period count. The full 255-period shift-register cycle is then run to show that the duty sequence does not repeat early.

// File: rtl/rdpwm_pkg.sv
package rdpwm_pkg;

  // Feedback masks for maximal-length sequences, bit k set for tap k+1.
  function automatic logic [15:0] tap_mask(int unsigned w);
    case (w)
      4:       return 16'h000C;
      5:       return 16'h0014;
      6:       return 16'h0030;
      7:       return 16'h0060;
      8:       return 16'h00B8;
      9:       return 16'h0110;
      10:      return 16'h0240;
      11:      return 16'h0500;
      12:      return 16'h0829;
      13:      return 16'h100D;
      14:      return 16'h2015;
      15:      return 16'h6000;
      16:      return 16'hD008;
      default: return 16'h0000;
    endcase
  endfunction

  // Raw (active-high) pulse level: count below compare value.
  function automatic logic pulse_level(logic [15:0] count, logic [15:0] cmp);
    return count < cmp;
  endfunction

endpackage

// File: rtl/rdpwm_timebase.sv
module rdpwm_timebase #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic          wrap_evt,
  output logic          at_zero
);
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)     cnt_q <= '0;
    else if (en) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt      = cnt_q;
  assign wrap_evt = en && (cnt_q == TOP);
  assign at_zero  = en && (cnt_q == '0);
endmodule

// File: rtl/rdpwm_lfsr.sv
module rdpwm_lfsr #(
  parameter int unsigned    W    = 8,
  parameter logic [W-1:0]   SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] TAPS = W'(rdpwm_pkg::tap_mask(W));

  logic [W-1:0] state_q;

  function automatic logic [W-1:0] step(logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      state_q <= SEED;
    else if (adv) state_q <= step(state_q);
  end

  assign state = state_q;
endmodule

// File: rtl/rdpwm_duty.sv
module rdpwm_duty #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] next_duty,
  input  logic [CW-1:0] cnt,
  input  logic          en,
  input  logic          pol,
  output logic [CW-1:0] duty,
  output logic          pwm
);
  logic [CW-1:0] duty_q;
  logic          raw;

  always_ff @(posedge clk) begin
    if (rst)       duty_q <= '0;
    else if (load) duty_q <= next_duty;
  end

  assign raw  = rdpwm_pkg::pulse_level(16'(cnt), 16'(duty_q));
  assign pwm  = en ? (raw ^ pol) : pol;
  assign duty = duty_q;
endmodule

// File: rtl/rdpwm_top.sv
module rdpwm_top #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEED  = 165
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             pol,
  output logic             pwm_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] duty_o
);
  localparam logic [CNT_W-1:0] SEED_T = CNT_W'(SEED);
  localparam logic [CNT_W-1:0] SEED_NZ = (SEED_T == '0) ? CNT_W'(1) : SEED_T;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lfsr_q;
  logic [CNT_W-1:0] duty_q;
  logic             wrap_evt;
  logic             at_zero;

  rdpwm_timebase #(.CW(CNT_W)) tb_i (
    .clk(clk), .rst(rst), .en(en),
    .cnt(cnt_q), .wrap_evt(wrap_evt), .at_zero(at_zero)
  );

  rdpwm_lfsr #(.W(CNT_W), .SEED(SEED_NZ)) rng_i (
    .clk(clk), .rst(rst), .adv(wrap_evt), .state(lfsr_q)
  );

  rdpwm_duty #(.CW(CNT_W)) cmp_i (
    .clk(clk), .rst(rst), .load(wrap_evt), .next_duty(lfsr_q),
    .cnt(cnt_q), .en(en), .pol(pol), .duty(duty_q), .pwm(pwm_o)
  );

  assign wrap_o = at_zero;
  assign duty_o = duty_q;
endmodule

// File: rtl/rdpwm_chk.sv
module rdpwm_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          pol,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] duty,
  input logic [CW-1:0] lfsr,
  input logic          wrap_evt,
  input logic          wrap_o,
  input logic          pwm_o
);
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> cnt == CW'($past(cnt) + 1'b1));

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(cnt) && $stable(lfsr) && $stable(duty)));

  // R4
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap_evt |=> $stable(duty));

  // R4
  duty_load_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> duty == $past(lfsr));

  // R5
  wrap_single_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> !wrap_o);

  // R6
  lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> (pwm_o == pol && !wrap_o));

  // R2
  period_start_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap_o && !pol && duty != '0) |-> pwm_o);
endmodule

bind rdpwm_top rdpwm_chk #(.CW(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .en(en), .pol(pol),
  .cnt(cnt_q), .duty(duty_q), .lfsr(lfsr_q),
  .wrap_evt(wrap_evt), .wrap_o(wrap_o), .pwm_o(pwm_o)
);

// File: tb/rdpwm_top_tb_top.sv
module rdpwm_top_tb_top;
  localparam logic [7:0] SEED = 8'hA5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic       pol = 1'b0;
  logic       pwm_o, wrap_o;
  logic [7:0] duty_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench-side state
  logic [7:0] m_cnt  = '0;
  logic [7:0] m_duty = '0;
  logic [7:0] m_lfsr = SEED;

  always #2 clk = ~clk;

  rdpwm_top #(.CNT_W(8), .SEED(165)) dut_i (
    .clk(clk), .rst(rst), .en(en), .pol(pol),
    .pwm_o(pwm_o), .wrap_o(wrap_o), .duty_o(duty_o)
  );

  // R6: taps at bits 7,5,4,3, shift toward MSB
  function automatic logic [7:0] rng_next(logic [7:0] s);
    logic fb;
    fb = s[7] ^ s[5] ^ s[4] ^ s[3];
    return {s[6:0], fb};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // One clock with given inputs; model advances, outputs checked at negedge.
  task automatic cyc(logic r, logic e, logic p);
    logic exp_pwm;
    rst = r; en = e; pol = p;
    if (r) begin
      m_cnt = '0; m_duty = '0; m_lfsr = SEED;
    end else if (e) begin
      if (m_cnt == 8'hFF) begin
        m_duty = m_lfsr;
        m_lfsr = rng_next(m_lfsr);
      end
      m_cnt = m_cnt + 8'd1;
    end
    @(negedge clk);
    exp_pwm = e ? ((m_cnt < m_duty) ^ p) : p;
    if (!e)     chk("R7", pwm_o, exp_pwm);
    else if (p) chk("R3", pwm_o, exp_pwm);
    else        chk("R2", pwm_o, exp_pwm);
    chk("R5", wrap_o, e && (m_cnt == 8'h00));
    chk("R4", duty_o, m_duty);
  endtask

  task automatic t_reset();
    repeat (3) cyc(1'b1, 1'b1, 1'b0);
    // R8: cleared duty, counter at zero shows as wrap strobe
    chk("R8", duty_o, 8'h00);
    chk("R8", wrap_o, 1'b1);
    chk("R8", pwm_o, 1'b0);
  endtask

  task automatic t_first_periods();
    // period after reset: duty 0, output never active
    int highs = 0;
    for (int i = 0; i < 255; i++) begin
      cyc(1'b0, 1'b1, 1'b0);
      if (pwm_o) highs++;
    end
    chk("R4", highs, 0);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R4", duty_o, SEED);
    highs = (pwm_o === 1'b1) ? 1 : 0;
    for (int i = 0; i < 255; i++) begin
      cyc(1'b0, 1'b1, 1'b0);
      if (pwm_o) highs++;
    end
    chk("R2", highs, 32'(SEED));
    cyc(1'b0, 1'b1, 1'b0);
    chk("R4", duty_o, rng_next(SEED));
  endtask

  task automatic t_polarity();
    int lows = 0;
    while (m_cnt != 8'hFF) cyc(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 256; i++) begin
      cyc(1'b0, 1'b1, 1'b1);
      if (!pwm_o) lows++;
    end
    chk("R3", lows, 32'(m_duty));
    while (m_cnt != 8'h80) cyc(1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_enable_hold();
    logic [7:0] d_before;
    while (m_cnt != 8'hFF) cyc(1'b0, 1'b1, 1'b0);
    d_before = duty_o;
    for (int i = 0; i < 12; i++) begin
      cyc(1'b0, 1'b0, i[0]);
      chk("R7", duty_o, d_before);
      chk("R7", wrap_o, 1'b0);
    end
    cyc(1'b0, 1'b1, 1'b0);
    chk("R4", wrap_o, 1'b1);
    chk("R7", duty_o, m_duty);
    while (m_cnt != 8'h40) cyc(1'b0, 1'b1, 1'b0);
    d_before = duty_o;
    for (int i = 0; i < 7; i++) cyc(1'b0, 1'b0, 1'b1);
    chk("R7", duty_o, d_before);
    chk("R7", pwm_o, 1'b1);
    cyc(1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_period_len();
    int gap;
    while (!wrap_o) cyc(1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      gap = 0;
      do begin
        cyc(1'b0, 1'b1, 1'b0);
        gap++;
      end while (!wrap_o);
      chk("R1", gap, 256);
    end
  endtask

  task automatic t_max_len();
    logic [7:0] d0;
    int wraps = 0;
    while (!wrap_o) cyc(1'b0, 1'b1, 1'b0);
    d0 = duty_o;
    do begin
      do cyc(1'b0, 1'b1, 1'b0); while (!wrap_o);
      wraps++;
      if (duty_o == 8'h00) chk("R6", duty_o, 8'h01);
    end while (duty_o != d0 && wraps < 300);
    chk("R6", wraps, 255);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_periods();
    t_polarity();
    t_enable_hold();
    t_period_len();
    t_max_len();
    t_reset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule